// File: doc/BRIEF.md
# Bank GPIO Register Block with Set/Clear Aliases

This block keeps the output level and the drive enable for every pin of one GPIO bank. Each pin has one bit. It also samples the bank's pin inputs through a short synchronizer so that software can read them. Access is through a 32-bit memory-mapped register port. Every register appears three times in the address space:

- a plain view, where a write replaces the register;
- a set view, where each 1 in the write data turns the matching bit on;
- a clear view, where each 1 in the write data turns the matching bit off.

Through the set and clear views, software can move one pin without a read-modify-write and without racing other users of the same bank. The output level and the enable go to the pin function mux. The sampled inputs come from the pad path.

A pin drives when its enable bit is 1 and is an input when its enable bit is 0. The safe way to make a pin drive is to program its level first and then set its enable. Because the two registers are independent, that order never produces a glitch of the wrong level on the pad.

Top module: `gpio_alias_bank`

## Requirements
- R1: After a synchronous reset every output-level bit, every enable bit and the read data are 0, so each pin starts as an input with a low level.
- R2: A write in the plain view (address bits [13:12] = 00) to offset 0x0 or 0x4 loads the write data into the output-level or enable register. The result shows on `pin_level` or `pin_drive` right after the clock edge that takes the write. Writing the level leaves the enable untouched.
- R3: A write in the set view (bits [13:12] = 10, i.e. base + 0x2000) turns on the register bits whose write-data bit is 1 and leaves every other bit unchanged.
- R4: A write in the clear view (bits [13:12] = 11, i.e. base + 0x3000) turns off the register bits whose write-data bit is 1 and leaves every other bit unchanged.
- R5: A read of offset 0x8 returns the pin inputs after `SYNC_STAGES` register stages. With the default of 2, a level sampled on `pin_in` at edge E is returned by a read whose request is taken at edge E+2 or later, and not by a read taken at E or E+1.
- R6: Offset 0x8 is read-only. A write to it through any view changes neither output register.
- R7: Reads through the set and clear views return the same value as a read of the plain view at the same offset.
- R8: Read data is registered. It appears on `csr_rdata` after the edge that takes the read request and holds until the next read.
- R9: Data bits at and above `NUM_PINS` are ignored on writes and read as 0.
- R10: An unmapped location reads as 0, and a write to it has no effect. Unmapped means the view 01 (base + 0x1000), or any offset other than 0x0, 0x4 and 0x8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_sel | input | 1 | Register access request for this cycle |
| csr_wr | input | 1 | 1 = write, 0 = read (qualified by csr_sel) |
| csr_addr | input | 14 | Byte address: [13:12] view, [11:0] register offset |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Pin levels from the pad path |
| pin_level | output | NUM_PINS | Output level per pin to the function mux |
| pin_drive | output | NUM_PINS | Drive enable per pin (1 = drive) |

## Verification
The input synchronizer and the read port work on their own schedules. A pin change and a read of the input register can therefore land in the same clock cycle. The bench provokes this by changing `pin_in` in the same half-cycle in which it raises a read of offset 0x8. It then keeps reading on the following edges. The read taken in the change cycle and the one taken a cycle later must return the old level, and the one taken two edges after the change must return the new level. A further test confirms that a level write made while the enable is 0 moves `pin_level` but not `pin_drive`.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

    localparam int unsigned BUS_W     = 32;
    localparam int unsigned ADDR_W    = 14;
    localparam int unsigned VIEW_LSB  = 12;

    localparam logic [VIEW_LSB-1:0] OFS_LEVEL = 12'h000;
    localparam logic [VIEW_LSB-1:0] OFS_DRIVE = 12'h004;
    localparam logic [VIEW_LSB-1:0] OFS_INPUT = 12'h008;

    // Address bits [13:12] select how a write is applied.
    typedef enum logic [1:0] {
        VIEW_PLAIN = 2'b00,
        VIEW_HOLE  = 2'b01,
        VIEW_SET   = 2'b10,
        VIEW_CLR   = 2'b11
    } view_e;

    typedef enum logic [1:0] {
        TGT_LEVEL = 2'd0,
        TGT_DRIVE = 2'd1,
        TGT_INPUT = 2'd2,
        TGT_NONE  = 2'd3
    } target_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        view_e            view;
        target_e          tgt;
        logic [BUS_W-1:0] data;
    } access_t;

    function automatic target_e target_of(logic [VIEW_LSB-1:0] ofs);
        target_e t;
        case (ofs)
            OFS_LEVEL: t = TGT_LEVEL;
            OFS_DRIVE: t = TGT_DRIVE;
            OFS_INPUT: t = TGT_INPUT;
            default:   t = TGT_NONE;
        endcase
        return t;
    endfunction

    function automatic logic [BUS_W-1:0] merge_view(
        view_e            v,
        logic [BUS_W-1:0] cur,
        logic [BUS_W-1:0] wdata
    );
        logic [BUS_W-1:0] nxt;
        case (v)
            VIEW_PLAIN: nxt = wdata;
            VIEW_SET:   nxt = cur | wdata;
            VIEW_CLR:   nxt = cur & ~wdata;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_alias_pkg::*;
(
    input  logic              csr_sel,
    input  logic              csr_wr,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [BUS_W-1:0]  csr_wdata,
    output access_t           acc
);

    view_e view_w;

    always_comb begin
        view_w   = view_e'(csr_addr[ADDR_W-1:VIEW_LSB]);
        acc.rd   = csr_sel & ~csr_wr;
        acc.wr   = csr_sel & csr_wr;
        acc.view = view_w;
        acc.data = csr_wdata;
        if (view_w == VIEW_HOLE) begin
            acc.tgt = TGT_NONE;
        end else begin
            acc.tgt = target_of(csr_addr[VIEW_LSB-1:0]);
        end
    end

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_alias_pkg::*;
#(
    parameter int unsigned WIDTH   = 28,
    parameter target_e     OWN_TGT = TGT_LEVEL
) (
    input  logic             clk,
    input  logic             rst,
    input  access_t          acc,
    output logic [WIDTH-1:0] q
);

    logic             hit;
    logic [BUS_W-1:0] wide_cur;
    logic [BUS_W-1:0] wide_nxt;

    always_comb begin
        hit               = acc.wr && (acc.tgt == OWN_TGT);
        wide_cur          = '0;
        wide_cur[WIDTH-1:0] = q;
        wide_nxt          = merge_view(acc.view, wide_cur, acc.data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (hit) begin
            q <= wide_nxt[WIDTH-1:0];
        end
    end

    // R2: plain write loads the pin bits of the data
    a_r2_plain_load: assert property (@(posedge clk) disable iff (rst)
        (hit && acc.view == VIEW_PLAIN) |=> (q == $past(acc.data[WIDTH-1:0])));

    // R3: set keeps old ones and adds the written ones
    a_r3_set_only_adds: assert property (@(posedge clk) disable iff (rst)
        (hit && acc.view == VIEW_SET) |=>
            (((q & $past(q)) == $past(q)) &&
             ((q & $past(acc.data[WIDTH-1:0])) == $past(acc.data[WIDTH-1:0]))));

    // R4: clear removes written ones and never adds a bit
    a_r4_clear_only_removes: assert property (@(posedge clk) disable iff (rst)
        (hit && acc.view == VIEW_CLR) |=>
            (((q & $past(acc.data[WIDTH-1:0])) == '0) && ((q & ~$past(q)) == '0)));

    // R6 and R10: any access not aimed at this register leaves it alone
    a_r6_foreign_access_hold: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(q));

endmodule

// File: rtl/gpio_in_sampler.sv
module gpio_in_sampler #(
    parameter int unsigned WIDTH  = 28,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= pin_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

    // R5: first stage captures the pad level at every edge
    a_r5_first_stage_capture: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (chain[0] == $past(pin_in)));

    generate
        if (STAGES > 1) begin : g_shift_chk
            // R5: each later stage takes its predecessor's value
            a_r5_stage_shift: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (chain[STAGES-1] == $past(chain[STAGES-2])));
        end
    endgenerate

endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank
    import gpio_alias_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 28,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                csr_sel,
    input  logic                csr_wr,
    input  logic [13:0]         csr_addr,
    input  logic [31:0]         csr_wdata,
    output logic [31:0]         csr_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_level,
    output logic [NUM_PINS-1:0] pin_drive
);

    localparam int unsigned NUM_CTL = 2;

    access_t                          acc;
    logic [NUM_CTL-1:0][NUM_PINS-1:0] ctl_q;
    logic [NUM_PINS-1:0]              in_q;
    logic [BUS_W-1:0]                 rd_word;
    logic [BUS_W-1:0]                 rdata_q;

    gpio_bus_decode u_decode (
        .csr_sel   (csr_sel),
        .csr_wr    (csr_wr),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .acc       (acc)
    );

    generate
        for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
            gpio_alias_reg #(
                .WIDTH   (NUM_PINS),
                .OWN_TGT (target_e'(g))
            ) u_reg (
                .clk (clk),
                .rst (rst),
                .acc (acc),
                .q   (ctl_q[g])
            );
        end
    endgenerate

    gpio_in_sampler #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .q      (in_q)
    );

    always_comb begin
        rd_word = '0;
        case (acc.tgt)
            TGT_LEVEL: rd_word[NUM_PINS-1:0] = ctl_q[TGT_LEVEL];
            TGT_DRIVE: rd_word[NUM_PINS-1:0] = ctl_q[TGT_DRIVE];
            TGT_INPUT: rd_word[NUM_PINS-1:0] = in_q;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (acc.rd) begin
            rdata_q <= rd_word;
        end
    end

    assign csr_rdata = rdata_q;
    assign pin_level = ctl_q[TGT_LEVEL];
    assign pin_drive = ctl_q[TGT_DRIVE];

    // R8: read data only moves on a read request
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !(csr_sel && !csr_wr) |=> $stable(csr_rdata));

    // R6: writes to the input register never reach the pins
    a_r6_input_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (csr_sel && csr_wr && csr_addr[11:0] == 12'h008) |=>
            ($stable(pin_level) && $stable(pin_drive)));

    // R10: the hole view neither writes nor returns data
    a_r10_hole_view_inert: assert property (@(posedge clk) disable iff (rst)
        (csr_sel && csr_addr[13:12] == 2'b01) |=>
            ($stable(pin_level) && $stable(pin_drive) &&
             (csr_wr ? 1'b1 : 1'b1) && ($past(csr_wr) || csr_rdata == '0)));

endmodule

// File: tb/gpio_alias_bank_bench.sv
`timescale 1ns/1ps
module gpio_alias_bank_bench;

    localparam int unsigned NP = 28;
    localparam logic [31:0] PIN_PAT = 32'h05A5_A5A5;
    localparam logic [31:0] PIN_ALT = 32'h0A5A_5A5A;

    typedef struct packed {
        logic        wr;
        logic [13:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_level;
        logic [31:0] exp_drive;
        logic [31:0] exp_rd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 14'h0000, 32'hFFFF_FFFF, 32'h0FFF_FFFF, 32'h0000_0000, 32'h0, 8'd9},  // R9 R2
        '{1'b0, 14'h0000, 32'h0,         32'h0FFF_FFFF, 32'h0000_0000, 32'h0FFF_FFFF, 8'd2}, // R2
        '{1'b1, 14'h3000, 32'h0000_00F0, 32'h0FFF_FF0F, 32'h0000_0000, 32'h0, 8'd4},  // R4
        '{1'b1, 14'h2004, 32'h0000_0011, 32'h0FFF_FF0F, 32'h0000_0011, 32'h0, 8'd3},  // R3
        '{1'b1, 14'h2004, 32'hF000_0100, 32'h0FFF_FF0F, 32'h0000_0111, 32'h0, 8'd3},  // R3 R9
        '{1'b0, 14'h2004, 32'h0,         32'h0FFF_FF0F, 32'h0000_0111, 32'h0000_0111, 8'd7}, // R7
        '{1'b0, 14'h3000, 32'h0,         32'h0FFF_FF0F, 32'h0000_0111, 32'h0FFF_FF0F, 8'd7}, // R7
        '{1'b1, 14'h3004, 32'h0000_0001, 32'h0FFF_FF0F, 32'h0000_0110, 32'h0, 8'd4},  // R4
        '{1'b1, 14'h0008, 32'h0000_1234, 32'h0FFF_FF0F, 32'h0000_0110, 32'h0, 8'd6},  // R6
        '{1'b1, 14'h2008, 32'hFFFF_FFFF, 32'h0FFF_FF0F, 32'h0000_0110, 32'h0, 8'd6},  // R6
        '{1'b1, 14'h3008, 32'hFFFF_FFFF, 32'h0FFF_FF0F, 32'h0000_0110, 32'h0, 8'd6},  // R6
        '{1'b0, 14'h0008, 32'h0,         32'h0FFF_FF0F, 32'h0000_0110, 32'h05A5_A5A5, 8'd5}, // R5
        '{1'b0, 14'h3008, 32'h0,         32'h0FFF_FF0F, 32'h0000_0110, 32'h05A5_A5A5, 8'd7}, // R7
        '{1'b1, 14'h1000, 32'h0000_0000, 32'h0FFF_FF0F, 32'h0000_0110, 32'h0, 8'd10}, // R10
        '{1'b0, 14'h1000, 32'h0,         32'h0FFF_FF0F, 32'h0000_0110, 32'h0, 8'd10}, // R10
        '{1'b1, 14'h000C, 32'h0000_0000, 32'h0FFF_FF0F, 32'h0000_0110, 32'h0, 8'd10}, // R10
        '{1'b0, 14'h000C, 32'h0,         32'h0FFF_FF0F, 32'h0000_0110, 32'h0, 8'd10}, // R10
        '{1'b1, 14'h0002, 32'h0000_0000, 32'h0FFF_FF0F, 32'h0000_0110, 32'h0, 8'd10}, // R10
        '{1'b1, 14'h0004, 32'hABCD_EF01, 32'h0FFF_FF0F, 32'h0BCD_EF01, 32'h0, 8'd9},  // R9
        '{1'b1, 14'h3000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0BCD_EF01, 32'h0, 8'd4},  // R4
        '{1'b0, 14'h0004, 32'h0,         32'h0000_0000, 32'h0BCD_EF01, 32'h0BCD_EF01, 8'd8}  // R8
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          csr_sel = 1'b0;
    logic          csr_wr = 1'b0;
    logic [13:0]   csr_addr = '0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic [NP-1:0] pin_in = PIN_PAT[NP-1:0];
    logic [NP-1:0] pin_level;
    logic [NP-1:0] pin_drive;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] last_rd = '0;

    always #2.5 clk = ~clk;

    gpio_alias_bank #(.NUM_PINS(NP), .SYNC_STAGES(2)) u_gpio_alias_bank (
        .clk       (clk),
        .rst       (rst),
        .csr_sel   (csr_sel),
        .csr_wr    (csr_wr),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .pin_in    (pin_in),
        .pin_level (pin_level),
        .pin_drive (pin_drive)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one access at the falling edge; it is taken at the next rising edge.
    task automatic access(logic wr, logic [13:0] addr, logic [31:0] wdata);
        @(negedge clk);
        csr_sel   = 1'b1;
        csr_wr    = wr;
        csr_addr  = addr;
        csr_wdata = wdata;
        @(posedge clk);
        #1;
        @(negedge clk);
        csr_sel = 1'b0;
        csr_wr  = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "level", {4'h0, pin_level}, 32'h0);
        check("R1", "drive", {4'h0, pin_drive}, 32'h0);
        check("R1", "rdata", csr_rdata, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(posedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            @(negedge clk);
            csr_sel   = 1'b1;
            csr_wr    = VECS[i].wr;
            csr_addr  = VECS[i].addr;
            csr_wdata = VECS[i].wdata;
            @(posedge clk);
            #1;
            check(tag, "level", {4'h0, pin_level}, VECS[i].exp_level);
            check(tag, "drive", {4'h0, pin_drive}, VECS[i].exp_drive);
            if (VECS[i].wr) begin
                check("R8", "rdata held on write", csr_rdata, last_rd);
            end else begin
                check(tag, "rdata", csr_rdata, VECS[i].exp_rd);
                last_rd = VECS[i].exp_rd;
            end
            @(negedge clk);
            csr_sel = 1'b0;
            csr_wr  = 1'b0;
        end

        // R8: idle cycles keep the last read word
        repeat (3) @(posedge clk);
        #1;
        check("R8", "rdata idle hold", csr_rdata, last_rd);

        // R2: value before enable; level moves while drive stays off for that pin
        access(1'b1, 14'h3004, 32'hFFFF_FFFF);
        access(1'b1, 14'h2000, 32'h0000_0008);
        check("R2", "level set before enable", {4'h0, pin_level}, 32'h0000_0008);
        check("R2", "drive still off", {4'h0, pin_drive}, 32'h0);
        access(1'b1, 14'h2004, 32'h0000_0008);
        check("R2", "drive after enable", {4'h0, pin_drive}, 32'h0000_0008);
        check("R2", "level unchanged by enable", {4'h0, pin_level}, 32'h0000_0008);

        // R5: pin change in the same cycle as an input read
        @(negedge clk);
        pin_in    = PIN_ALT[NP-1:0];
        csr_sel   = 1'b1;
        csr_wr    = 1'b0;
        csr_addr  = 14'h0008;
        @(posedge clk);
        #1;
        check("R5", "read at change edge", csr_rdata, PIN_PAT);
        @(posedge clk);
        #1;
        check("R5", "read one edge later", csr_rdata, PIN_PAT);
        @(posedge clk);
        #1;
        check("R5", "read two edges later", csr_rdata, PIN_ALT);
        @(negedge clk);
        csr_sel = 1'b0;

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "level after reset", {4'h0, pin_level}, 32'h0);
        check("R1", "drive after reset", {4'h0, pin_drive}, 32'h0);
        check("R1", "rdata after reset", csr_rdata, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule